// File: doc/BRIEF.md
# Full/Empty Tagged Memory

A word-addressed memory with several access ports, where each word carries a one-bit presence tag. A tag of 0 means the word is empty: nothing has been produced into it yet, or its value has already been consumed. A tag of 1 means it is full. Plain loads and stores ignore the tag and never change it. Synchronizing accesses are chosen per request by a sync bit, and they wait on the tag. A synchronizing write (put) waits until its word is empty, then stores the data and marks the word full. A synchronizing read (take) waits until its word is full, then returns the data and marks the word empty.

A requester raises `req` with its command and keeps it steady until `ready` is seen high in the same cycle. The access takes effect at that clock edge. Read data appears on `rdata` during the accept cycle. While a request is blocked, its port shows `ready` low. A separate init command writes any tag directly. When a take or put on one port releases a word, a request that another port was holding on that word completes one cycle later. This gives a hardware handoff between producer and consumer.

Top module: `fe_tagged_mem`

## Requirements
- R1: After reset every tag is empty: a take to any address stalls, and a plain load of any address returns 0.
- R2: A put (sync=1, we=1) to an empty word is accepted in the same cycle it is presented. It writes the data and sets the tag to full.
- R3: A put to a full word holds `ready` low and leaves the stored data unchanged.
- R4: A take (sync=1, we=0) to a full word is accepted in the same cycle. It returns the stored word on `rdata` in that cycle and clears the tag to empty.
- R5: A take to an empty word holds `ready` low.
- R6: Plain loads (sync=0, we=0) and plain stores (sync=0, we=1) are accepted whatever the tag. A plain store writes the data but leaves the tag unchanged, and a plain load returns the stored word.
- R7: While `init_en` is high, the tag at `init_addr` is written with `init_full` at the clock edge. Every port access to that address is held off during that cycle.
- R8: A request held off by the tag completes on the cycle after another port's take or put releases the word in the same clock edge.
- R9: When several ports reach one address in the same cycle, only the lowest-numbered port whose tag condition holds is accepted. Ports on different addresses proceed together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NP | Per-port request valid |
| we | input | NP | Per-port write (1) or read (0) |
| sync | input | NP | Per-port synchronizing access (1) or plain access (0) |
| addr | input | NP*AW | Per-port word address, port p at bits [p*AW +: AW] |
| wdata | input | NP*DW | Per-port write data |
| ready | output | NP | Per-port accept, high in the cycle the access takes effect |
| rdata | output | NP*DW | Per-port read data, valid while req and ready are high |
| init_en | input | 1 | Direct tag write enable |
| init_addr | input | AW | Address of the direct tag write |
| init_full | input | 1 | Tag value for the direct write (1 full, 0 empty) |

## Verification
`ready` and `rdata` are combinational from the registered tags and data, so the bench checks them in the same cycle a request is presented. It drives inputs at the falling edge and samples 2 ns later, before the rising edge that commits the access. The tag or data change made by an accepted access is visible from the next cycle only, so every follow-up check is placed one full cycle after the request. In the release case the waiting port is sampled low in the release cycle and high in the next one. The address sweep repeats the put, take, store and init sequence on every word of an 8-word instance.

// File: rtl/fe_pkg.sv
package fe_pkg;

   // command encoding: {sync, we}
   typedef enum logic [1:0] {
      FE_LOAD  = 2'b00,
      FE_STORE = 2'b01,
      FE_TAKE  = 2'b10,
      FE_PUT   = 2'b11
   } fe_kind_e;

   function automatic fe_kind_e fe_decode(input logic sync_i, input logic we_i);
      return fe_kind_e'({sync_i, we_i});
   endfunction

endpackage

// File: rtl/fe_port_gate.sv
module fe_port_gate
   import fe_pkg::*;
#(
   parameter int NP = 2,
   parameter int AW = 4
) (
   input  logic [NP-1:0]    req_i,
   input  logic [2*NP-1:0]  kind_i,
   input  logic [NP*AW-1:0] addr_i,
   input  logic [NP-1:0]    tag_i,
   input  logic             init_en_i,
   input  logic [AW-1:0]    init_addr_i,
   output logic [NP-1:0]    grant_o
);

   always_comb begin
      logic [NP-1:0] g;
      logic          ok;
      logic          hold;
      g = '0;
      for (int p = 0; p < NP; p++) begin
         case (fe_kind_e'(kind_i[2*p +: 2]))
            FE_PUT:  ok = !tag_i[p];
            FE_TAKE: ok = tag_i[p];
            default: ok = 1'b1;
         endcase
         hold = init_en_i && (addr_i[p*AW +: AW] == init_addr_i);
         for (int q = 0; q < p; q++) begin
            if (g[q] && (addr_i[q*AW +: AW] == addr_i[p*AW +: AW])) hold = 1'b1;
         end
         g[p] = req_i[p] && ok && !hold;
      end
      grant_o = g;
   end

endmodule

// File: rtl/fe_tag_array.sv
module fe_tag_array
   import fe_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int AW    = 4,
   parameter int NP    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NP-1:0]    grant_i,
   input  logic [2*NP-1:0]  kind_i,
   input  logic [NP*AW-1:0] addr_i,
   input  logic             init_en_i,
   input  logic [AW-1:0]    init_addr_i,
   input  logic             init_full_i,
   output logic [NP-1:0]    tag_o
);

   logic [DEPTH-1:0] tags;
   logic [DEPTH-1:0] tags_nxt;

   always_comb begin
      tags_nxt = tags;
      for (int p = 0; p < NP; p++) begin
         if (grant_i[p]) begin
            case (fe_kind_e'(kind_i[2*p +: 2]))
               FE_PUT:  tags_nxt[addr_i[p*AW +: AW]] = 1'b1;
               FE_TAKE: tags_nxt[addr_i[p*AW +: AW]] = 1'b0;
               default: ;
            endcase
         end
      end
      if (init_en_i) tags_nxt[init_addr_i] = init_full_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tags <= '0;
      else        tags <= tags_nxt;
   end

   for (genvar p = 0; p < NP; p++) begin : g_look
      logic [AW-1:0] a_w;
      fe_kind_e      k_w;
      assign a_w      = addr_i[p*AW +: AW];
      assign k_w      = fe_kind_e'(kind_i[2*p +: 2]);
      assign tag_o[p] = tags[a_w];

      assert_put_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (grant_i[p] && k_w == FE_PUT) |=> tags[$past(a_w)]);

      assert_take_drains_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (grant_i[p] && k_w == FE_TAKE) |=> !tags[$past(a_w)]);

      assert_plain_keeps_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (grant_i[p] && !k_w[1]) |=> (tags[$past(a_w)] == $past(tags[a_w])));
   end

endmodule

// File: rtl/fe_data_array.sv
module fe_data_array #(
   parameter int DEPTH = 16,
   parameter int AW    = 4,
   parameter int DW    = 8,
   parameter int NP    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NP-1:0]    grant_i,
   input  logic [2*NP-1:0]  kind_i,
   input  logic [NP*AW-1:0] addr_i,
   input  logic [NP*DW-1:0] wdata_i,
   output logic [NP*DW-1:0] rdata_o
);

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         for (int p = 0; p < NP; p++) begin
            // kind bit 0 is the write flag
            if (grant_i[p] && kind_i[2*p]) mem[addr_i[p*AW +: AW]] <= wdata_i[p*DW +: DW];
         end
      end
   end

   for (genvar p = 0; p < NP; p++) begin : g_rd
      assign rdata_o[p*DW +: DW] = mem[addr_i[p*AW +: AW]];
      for (genvar q = p + 1; q < NP; q++) begin : g_pair
         assert_one_word_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !(grant_i[p] && grant_i[q] && (addr_i[p*AW +: AW] == addr_i[q*AW +: AW])));
      end
   end

endmodule

// File: rtl/fe_tagged_mem.sv
module fe_tagged_mem
   import fe_pkg::*;
#(
   parameter int DW    = 8,
   parameter int DEPTH = 16,
   parameter int NP    = 2,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NP-1:0]    req,
   input  logic [NP-1:0]    we,
   input  logic [NP-1:0]    sync,
   input  logic [NP*AW-1:0] addr,
   input  logic [NP*DW-1:0] wdata,
   output logic [NP-1:0]    ready,
   output logic [NP*DW-1:0] rdata,
   input  logic             init_en,
   input  logic [AW-1:0]    init_addr,
   input  logic             init_full
);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("fe_tagged_mem: DEPTH must be a power of two of at least 2");
   end
   if (NP < 1) begin : g_bad_np
      $error("fe_tagged_mem: NP must be at least 1");
   end
   if (DW < 1) begin : g_bad_dw
      $error("fe_tagged_mem: DW must be at least 1");
   end

   logic [2*NP-1:0] kind;
   logic [NP-1:0]   tag_at;
   logic [NP-1:0]   grant;

   for (genvar p = 0; p < NP; p++) begin : g_kind
      assign kind[2*p +: 2] = fe_decode(sync[p], we[p]);
   end

   fe_port_gate #(.NP(NP), .AW(AW)) u_gate (
      .req_i       (req),
      .kind_i      (kind),
      .addr_i      (addr),
      .tag_i       (tag_at),
      .init_en_i   (init_en),
      .init_addr_i (init_addr),
      .grant_o     (grant)
   );

   fe_tag_array #(.DEPTH(DEPTH), .AW(AW), .NP(NP)) u_tags (
      .clk         (clk),
      .rst_n       (rst_n),
      .grant_i     (grant),
      .kind_i      (kind),
      .addr_i      (addr),
      .init_en_i   (init_en),
      .init_addr_i (init_addr),
      .init_full_i (init_full),
      .tag_o       (tag_at)
   );

   fe_data_array #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .NP(NP)) u_data (
      .clk     (clk),
      .rst_n   (rst_n),
      .grant_i (grant),
      .kind_i  (kind),
      .addr_i  (addr),
      .wdata_i (wdata),
      .rdata_o (rdata)
   );

   assign ready = grant;

   for (genvar p = 0; p < NP; p++) begin : g_chk
      assert_put_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (req[p] && sync[p] && we[p] && tag_at[p]) |-> !ready[p]);

      assert_take_waits_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (req[p] && sync[p] && !we[p] && !tag_at[p]) |-> !ready[p]);

      assert_init_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (init_en && req[p] && addr[p*AW +: AW] == init_addr) |-> !ready[p]);
   end

endmodule

// File: tb/fe_tagged_mem_tb.sv
module fe_tagged_mem_tb;
   localparam int DW = 8;
   localparam int DEPTH = 8;
   localparam int NP = 2;
   localparam int AW = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NP-1:0]    req = '0, we = '0, sync = '0;
   logic [NP*AW-1:0] addr = '0;
   logic [NP*DW-1:0] wdata = '0;
   logic [NP-1:0]    ready;
   logic [NP*DW-1:0] rdata;
   logic             init_en = 1'b0;
   logic [AW-1:0]    init_addr = '0;
   logic             init_full = 1'b0;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   fe_tagged_mem #(.DW(DW), .DEPTH(DEPTH), .NP(NP)) u_dut (
      .clk(clk), .rst_n(rst_n), .req(req), .we(we), .sync(sync), .addr(addr),
      .wdata(wdata), .ready(ready), .rdata(rdata), .init_en(init_en),
      .init_addr(init_addr), .init_full(init_full)
   );

   task automatic chk(input string rq, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   // start a new cycle: all idle after the falling edge
   task automatic next_cycle();
      @(negedge clk);
      req = '0; we = '0; sync = '0; init_en = 1'b0;
   endtask

   task automatic drive(input int p, input bit s, input bit w, input int a, input int d);
      req[p] = 1'b1; sync[p] = s; we[p] = w;
      addr[p*AW +: AW] = AW'(a);
      wdata[p*DW +: DW] = DW'(d);
   endtask

   function automatic int rd(input int p);
      return int'(rdata[p*DW +: DW]);
   endfunction

   initial begin
      repeat (3) @(posedge clk);
      next_cycle();
      rst_n = 1'b1;

      // R1: reset state swept over every address
      for (int a = 0; a < DEPTH; a++) begin
         next_cycle();
         drive(0, 1, 0, a, 0);
         drive(1, 0, 0, a, 0);
         #2;
         chk("R1", "take after reset ready", int'(ready[0]), 0);
         chk("R1", "load after reset data", rd(1), 0);
      end

      // per-address producer/consumer sequence
      for (int a = 0; a < DEPTH; a++) begin
         int d = (a * 37 + 5) & 8'hFF;
         int s = (d + 1) & 8'hFF;
         next_cycle(); drive(0, 1, 1, a, d); #2;
         chk("R2", "put on empty ready", int'(ready[0]), 1);
         next_cycle(); drive(0, 1, 1, a, d ^ 8'hFF); drive(1, 0, 0, a, 0); #2;
         chk("R3", "put on full ready", int'(ready[0]), 0);
         chk("R6", "load on full ready", int'(ready[1]), 1);
         chk("R3", "data kept under blocked put", rd(1), d);
         next_cycle(); drive(1, 1, 0, a, 0); #2;
         chk("R4", "take on full ready", int'(ready[1]), 1);
         chk("R4", "take data", rd(1), d);
         next_cycle(); drive(1, 1, 0, a, 0); drive(0, 0, 1, a, s); #2;
         chk("R5", "take on empty ready", int'(ready[1]), 0);
         chk("R6", "store on empty ready", int'(ready[0]), 1);
         next_cycle(); drive(1, 1, 0, a, 0); drive(0, 0, 0, a, 0); #2;
         chk("R6", "tag still empty after store", int'(ready[1]), 0);
         chk("R6", "load returns stored", rd(0), s);
         next_cycle(); init_en = 1'b1; init_addr = AW'(a); init_full = 1'b1;
         drive(0, 0, 1, a, 8'h00); #2;
         chk("R7", "store blocked by init", int'(ready[0]), 0);
         next_cycle(); drive(0, 1, 0, a, 0); #2;
         chk("R7", "take after init set ready", int'(ready[0]), 1);
         chk("R7", "take after init set data", rd(0), s);
      end

      // R8: release by port 0 frees a put stalled on port 1
      next_cycle(); drive(0, 1, 1, 2, 8'h11); #2;
      chk("R8", "first put ready", int'(ready[0]), 1);
      next_cycle(); drive(1, 1, 1, 2, 8'h22); #2;
      chk("R8", "second put stalls", int'(ready[1]), 0);
      next_cycle(); drive(1, 1, 1, 2, 8'h22); drive(0, 1, 0, 2, 0); #2;
      chk("R8", "take in release cycle", rd(0), 8'h11);
      chk("R8", "stalled put in release cycle", int'(ready[1]), 0);
      next_cycle(); drive(1, 1, 1, 2, 8'h22); #2;
      chk("R8", "stalled put completes next cycle", int'(ready[1]), 1);
      next_cycle(); drive(0, 1, 0, 2, 0); #2;
      chk("R8", "handed-off data", rd(0), 8'h22);

      // R9: same-address contention
      next_cycle(); drive(0, 0, 0, 3, 0); drive(1, 0, 0, 3, 0); #2;
      chk("R9", "port0 wins load", int'(ready[0]), 1);
      chk("R9", "port1 loses load", int'(ready[1]), 0);
      next_cycle(); drive(0, 0, 0, 3, 0); drive(1, 0, 0, 4, 0); #2;
      chk("R9", "distinct addresses both ready", int'(ready), 3);
      next_cycle(); drive(0, 1, 1, 5, 8'hA5); drive(1, 1, 1, 5, 8'h5A); #2;
      chk("R9", "put contention", int'(ready), 1);
      next_cycle(); drive(1, 0, 0, 5, 0); #2;
      chk("R9", "winner data stored", rd(1), 8'hA5);
      next_cycle(); init_en = 1'b1; init_addr = 3'd5; init_full = 1'b0; #2;
      next_cycle(); drive(0, 1, 0, 5, 0); #2;
      chk("R7", "take after init clear", int'(ready[0]), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule